// File: doc/BRIEF.md
# Coprocessor Lazy-Switch Trap Gate

This block sits between the instruction decode stage of an integer core and the command port of a numeric coprocessor. It holds the core's machine status word, in which one bit is a task-switched flag. A task switch only raises that flag. It leaves the coprocessor's contents alone. The first coprocessor-touching instruction after the switch (an escape or a wait) is refused and turned into a not-present exception. The handler can then decide whether the coprocessor context needs to be exchanged. Once the handler clears the flag, the retried instruction goes through.

The coprocessor runs apart from the core, so an error it reports can arrive at any time. The gate latches such an error and delivers it only when the next escape or wait is decoded. If that instruction also meets a set task-switched flag, the not-present exception wins and the error stays latched. This lets the error be serviced later, in the task it belongs to.

Instructions arrive on a valid/ready stream. Escape and wait commands that are allowed through leave on a second valid/ready stream towards the coprocessor. When the coprocessor deasserts ready, the gate deasserts ready towards decode in the same cycle and raises the stall output. Decode must then hold the instruction stable until it is taken. Exceptions appear as a one-cycle pulse with an 8-bit vector number. For the cycle of that pulse, the gate refuses every escape or wait. After an exception pulse, the issuer is expected to withdraw the instruction.

Top module: `cpx_trap_gate`

## Requirements
- R1: After reset the status word is all zero, no error is latched, `exc_valid` is 0, and an instruction of the "other" kind is accepted at once.
- R2: `ts_set` makes bit 3 of `msw` 1 on the next cycle. `ts_clr` makes it 0 on the next cycle. When both are asserted, `ts_set` wins. `msw_ld` loads the whole word from `msw_din`, and for bit 3 it ranks below both strobes.
- R3: Instruction kind encoding is 2'b01 escape, 2'b10 wait, and 2'b00 or 2'b11 other. An escape or wait presented while bit 3 is set is not forwarded (`cop_valid`=0) and is stalled (`ins_ready`=0, `stall`=1). One cycle later, `exc_valid` pulses with `exc_vector`=7.
- R4: If an escape or wait meets both a set bit 3 and a latched error, vector 7 is reported and the error stays latched.
- R5: A `cop_err` pulse latches an error. The next escape or wait with bit 3 clear is not forwarded, and one cycle later `exc_valid` pulses with `exc_vector`=16. The error is then cleared, so a following escape is forwarded.
- R6: `cop_rst` clears a latched error and takes priority over a `cop_err` in the same cycle.
- R7: With bit 3 clear and no error latched, an escape or wait is forwarded. In that case `cop_valid`=1, `cop_data` equals `ins_data`, `cop_wait` is 1 for a wait and 0 for an escape, and `ins_ready` follows `cop_ready` (stall while the coprocessor is not ready).
- R8: Instructions of the "other" kind are always accepted with no stall, are never forwarded and raise no exception, whatever the flag or error state.
- R9: `exc_valid` is high for exactly one cycle. In that cycle an escape or wait still presented is refused and not forwarded.
- R10: After the handler clears bit 3, a retried escape is forwarded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Decode presents an instruction |
| ins_ready | output | 1 | Gate accepts the instruction this cycle |
| ins_kind | input | 2 | 01 escape, 10 wait, 00/11 other |
| ins_data | input | INS_W | Instruction payload |
| cop_valid | output | 1 | Command offered to the coprocessor |
| cop_ready | input | 1 | Coprocessor takes the command |
| cop_data | output | INS_W | Forwarded payload |
| cop_wait | output | 1 | Forwarded command is a wait |
| cop_err | input | 1 | Asynchronous numeric error report (one-cycle pulse) |
| cop_rst | input | 1 | Coprocessor reset, clears the latched error |
| stall | output | 1 | Presented instruction is being held |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_vector | output | 8 | Exception vector number |
| ts_set | input | 1 | Task switch completes: set bit 3 |
| ts_clr | input | 1 | Handler clears bit 3 |
| msw_ld | input | 1 | Load the status word |
| msw_din | input | MSW_W | Status word load value |
| msw | output | MSW_W | Current status word |

## Verification
`ins_ready`, `stall`, `cop_valid`, `cop_data` and `cop_wait` are combinational, so the bench checks them in the same cycle the instruction is presented. `exc_valid`, `exc_vector` and the status word are registered, so the bench checks them one cycle after the stimulus, and it checks `exc_valid` low again the cycle after that. Flag and error changes are set up one clock before an instruction is presented, which means each check samples a register that has already been updated.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  typedef enum logic [1:0] {
    K_OTHER = 2'b00,
    K_ESC   = 2'b01,
    K_WAIT  = 2'b10,
    K_RSV   = 2'b11
  } kind_e;

  function automatic logic touches_cop(input logic [1:0] k);
    return (k == K_ESC) || (k == K_WAIT);
  endfunction
endpackage

// File: rtl/cpx_msw_reg.sv
module cpx_msw_reg #(
  parameter int MSW_W  = 16,
  parameter int TS_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts_set,
  input  logic             ts_clr,
  input  logic             msw_ld,
  input  logic [MSW_W-1:0] msw_din,
  output logic [MSW_W-1:0] msw,
  output logic             ts
);
  logic [MSW_W-1:0] word_q;

  for (genvar i = 0; i < MSW_W; i++) begin : g_bit
    if (i == TS_BIT) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)      word_q[i] <= 1'b0;
        else if (ts_set) word_q[i] <= 1'b1;
        else if (ts_clr) word_q[i] <= 1'b0;
        else if (msw_ld) word_q[i] <= msw_din[i];
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)      word_q[i] <= 1'b0;
        else if (msw_ld) word_q[i] <= msw_din[i];
      end
    end
  end

  assign msw = word_q;
  assign ts  = word_q[TS_BIT];

  // R2
  ts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_set |=> ts);
  // R2
  ts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_clr && !ts_set) |=> !ts);
endmodule

// File: rtl/cpx_err_latch.sv
module cpx_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cop_err,
  input  logic cop_rst,
  input  logic err_ack,
  output logic err
);
  logic err_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (cop_rst) err_q <= 1'b0;
    else if (cop_err) err_q <= 1'b1;
    else if (err_ack) err_q <= 1'b0;
  end

  assign err = err_q;

  // R6
  err_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_rst |=> !err);
  // R4
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_ack && !cop_rst) |=> err);
endmodule

// File: rtl/cpx_dispatch.sv
module cpx_dispatch
  import cpx_pkg::*;
#(
  parameter int         INS_W   = 32,
  parameter logic [7:0] NM_VEC  = 8'd7,
  parameter logic [7:0] ERR_VEC = 8'd16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [1:0]       ins_kind,
  input  logic [INS_W-1:0] ins_data,
  output logic             ins_ready,
  output logic             cop_valid,
  input  logic             cop_ready,
  output logic [INS_W-1:0] cop_data,
  output logic             cop_wait,
  input  logic             ts,
  input  logic             err,
  output logic             err_ack,
  output logic             stall,
  output logic             exc_valid,
  output logic [7:0]       exc_vector
);
  logic       is_cop;
  logic       gate_open;
  logic       trap_nm;
  logic       trap_er;
  logic       exc_q;
  logic [7:0] vec_q;

  assign is_cop    = touches_cop(ins_kind);
  assign gate_open = ins_valid && is_cop && !exc_q;
  assign trap_nm   = gate_open && ts;
  assign trap_er   = gate_open && !ts && err;

  assign cop_valid = gate_open && !ts && !err;
  assign cop_data  = ins_data;
  assign cop_wait  = (kind_e'(ins_kind) == K_WAIT);
  assign ins_ready = !is_cop || (cop_valid && cop_ready);
  assign stall     = ins_valid && !ins_ready;
  assign err_ack   = trap_er;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_q <= 1'b0;
      vec_q <= 8'd0;
    end else begin
      exc_q <= trap_nm || trap_er;
      if (trap_nm)      vec_q <= NM_VEC;
      else if (trap_er) vec_q <= ERR_VEC;
    end
  end

  assign exc_valid  = exc_q;
  assign exc_vector = vec_q;

  // R3
  nm_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && is_cop && ts && !exc_valid) |=> (exc_valid && exc_vector == NM_VEC));
  // R3
  no_fwd_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_valid |-> !ts);
  // R9
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid);
  // R9
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !cop_valid);
  // R8
  other_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !is_cop) |-> (ins_ready && !cop_valid && !stall));
  // R5
  err_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && is_cop && !ts && err && !exc_valid) |=> (exc_valid && exc_vector == ERR_VEC));
endmodule

// File: rtl/cpx_trap_gate.sv
module cpx_trap_gate #(
  parameter int         INS_W   = 32,
  parameter int         MSW_W   = 16,
  parameter int         TS_BIT  = 3,
  parameter logic [7:0] NM_VEC  = 8'd7,
  parameter logic [7:0] ERR_VEC = 8'd16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [1:0]       ins_kind,
  input  logic [INS_W-1:0] ins_data,
  output logic             cop_valid,
  input  logic             cop_ready,
  output logic [INS_W-1:0] cop_data,
  output logic             cop_wait,
  input  logic             cop_err,
  input  logic             cop_rst,
  output logic             stall,
  output logic             exc_valid,
  output logic [7:0]       exc_vector,
  input  logic             ts_set,
  input  logic             ts_clr,
  input  logic             msw_ld,
  input  logic [MSW_W-1:0] msw_din,
  output logic [MSW_W-1:0] msw
);
  logic ts;
  logic err;
  logic err_ack;

  cpx_msw_reg #(.MSW_W(MSW_W), .TS_BIT(TS_BIT)) u_msw (
    .clk(clk), .rst_n(rst_n), .ts_set(ts_set), .ts_clr(ts_clr),
    .msw_ld(msw_ld), .msw_din(msw_din), .msw(msw), .ts(ts)
  );

  cpx_err_latch u_err (
    .clk(clk), .rst_n(rst_n), .cop_err(cop_err), .cop_rst(cop_rst),
    .err_ack(err_ack), .err(err)
  );

  cpx_dispatch #(.INS_W(INS_W), .NM_VEC(NM_VEC), .ERR_VEC(ERR_VEC)) u_disp (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_kind(ins_kind),
    .ins_data(ins_data), .ins_ready(ins_ready), .cop_valid(cop_valid),
    .cop_ready(cop_ready), .cop_data(cop_data), .cop_wait(cop_wait),
    .ts(ts), .err(err), .err_ack(err_ack), .stall(stall),
    .exc_valid(exc_valid), .exc_vector(exc_vector)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!exc_valid && msw == '0));
endmodule

// File: tb/cpx_trap_gate_tb.sv
module cpx_trap_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int INS_W = 32;
  localparam int MSW_W = 16;
  localparam int NROWS = 10;
  // row: {kind[15:14], ts[13], err[12], crdy[11], exp_cv[10], exp_rdy[9], exp_exc[8], exp_vec[7:0]}
  localparam logic [15:0] ROWS [NROWS] = '{
    {2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'd0},
    {2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0},
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0},
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0},
    {2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd7},
    {2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd7},
    {2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd16},
    {2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd16},
    {2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd7},
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_ready;
  logic [1:0] ins_kind = 2'b00;
  logic [INS_W-1:0] ins_data = '0;
  logic cop_valid, cop_ready = 1'b1, cop_wait;
  logic [INS_W-1:0] cop_data;
  logic cop_err = 1'b0, cop_rst = 1'b0, stall, exc_valid;
  logic [7:0] exc_vector;
  logic ts_set = 1'b0, ts_clr = 1'b0, msw_ld = 1'b0;
  logic [MSW_W-1:0] msw_din = '0, msw;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpx_trap_gate u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_kind(ins_kind), .ins_data(ins_data), .cop_valid(cop_valid),
    .cop_ready(cop_ready), .cop_data(cop_data), .cop_wait(cop_wait),
    .cop_err(cop_err), .cop_rst(cop_rst), .stall(stall),
    .exc_valid(exc_valid), .exc_vector(exc_vector), .ts_set(ts_set),
    .ts_clr(ts_clr), .msw_ld(msw_ld), .msw_din(msw_din), .msw(msw)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_ts_set();
    ts_set = 1'b1; tick(); ts_set = 1'b0;
  endtask

  task automatic pulse_ts_clr();
    ts_clr = 1'b1; tick(); ts_clr = 1'b0;
  endtask

  task automatic pulse_err();
    cop_err = 1'b1; tick(); cop_err = 1'b0;
  endtask

  task automatic pulse_crst();
    cop_rst = 1'b1; tick(); cop_rst = 1'b0;
  endtask

  task automatic present(input logic [1:0] k, input logic [31:0] d);
    ins_kind = k; ins_data = d; ins_valid = 1'b1; #1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 msw", msw, 0);
    chk("R1 exc_valid", exc_valid, 0);
    present(2'b00, 32'h1);
    chk("R1 other accepted", ins_ready, 1);
    ins_valid = 1'b0;
    tick();

    // table walk: R3 R4 R5 R7 R8
    for (int i = 0; i < NROWS; i++) begin
      logic [15:0] r;
      r = ROWS[i];
      pulse_crst();
      pulse_ts_clr();
      if (r[13]) pulse_ts_set();
      if (r[12]) pulse_err();
      cop_ready = r[11];
      present(r[15:14], 32'hC0DE_0000 + i);
      chk($sformatf("R7/R3 row%0d cop_valid", i), cop_valid, r[10]);
      chk($sformatf("R7/R8 row%0d ins_ready", i), ins_ready, r[9]);
      chk($sformatf("R7/R8 row%0d stall", i), stall, !r[9]);
      if (r[10]) begin
        chk($sformatf("R7 row%0d cop_data", i), cop_data, 32'hC0DE_0000 + i);
        chk($sformatf("R7 row%0d cop_wait", i), cop_wait, r[15:14] == 2'b10);
      end
      tick();
      chk($sformatf("R3/R5 row%0d exc_valid", i), exc_valid, r[8]);
      if (r[8]) begin
        chk($sformatf("R3/R4/R5 row%0d vector", i), exc_vector, r[7:0]);
        chk($sformatf("R9 row%0d held ready", i), ins_ready, 0);
        chk($sformatf("R9 row%0d no fwd", i), cop_valid, 0);
      end
      ins_valid = 1'b0;
      tick();
      chk($sformatf("R9 row%0d pulse ends", i), exc_valid, 0);
    end
    cop_ready = 1'b1;

    // R4 then R5: error survives a vector 7 trap, is reported after clear, then gone
    pulse_crst();
    pulse_ts_set();
    pulse_err();
    present(2'b01, 32'hA);
    tick();
    chk("R4 vector 7 first", exc_vector, 7);
    ins_valid = 1'b0;
    tick();
    pulse_ts_clr();
    present(2'b01, 32'hA);
    chk("R4 error kept, not forwarded", cop_valid, 0);
    tick();
    chk("R5 error vector", exc_vector, 16);
    chk("R5 error pulse", exc_valid, 1);
    ins_valid = 1'b0;
    tick();
    present(2'b01, 32'hA);
    chk("R5 error cleared, forwarded", cop_valid, 1);
    ins_valid = 1'b0;
    tick();

    // R6: reset beats a simultaneous error
    cop_rst = 1'b1; cop_err = 1'b1; tick(); cop_rst = 1'b0; cop_err = 1'b0;
    present(2'b10, 32'hB);
    chk("R6 rst over err", cop_valid, 1);
    ins_valid = 1'b0;
    tick();

    // R2: set wins over clear; load ranks lowest on bit 3
    ts_set = 1'b1; ts_clr = 1'b1; tick(); ts_set = 1'b0; ts_clr = 1'b0;
    chk("R2 set over clear", msw[3], 1);
    msw_ld = 1'b1; msw_din = 16'h0000; ts_set = 1'b1; tick();
    msw_ld = 1'b0; ts_set = 1'b0;
    chk("R2 set over load", msw, 16'h0008);
    msw_ld = 1'b1; msw_din = 16'h00F7; ts_clr = 1'b1; tick();
    msw_ld = 1'b0; ts_clr = 1'b0;
    chk("R2 clear over load", msw, 16'h00F7);
    msw_ld = 1'b1; msw_din = 16'h0009; tick(); msw_ld = 1'b0;
    chk("R2 load word", msw, 16'h0009);

    // R10: trap, handler clears, retry proceeds
    present(2'b01, 32'h55);
    chk("R10 trapped first", cop_valid, 0);
    tick();
    ins_valid = 1'b0;
    pulse_ts_clr();
    present(2'b01, 32'h55);
    chk("R10 retry forwarded", cop_valid, 1);
    chk("R10 retry accepted", ins_ready, 1);
    ins_valid = 1'b0;
    tick();
    chk("R10 no exception on retry", exc_valid, 0);

    done = 1'b1;
    finish_run();
  end
endmodule